// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block resolves one 6-bit operand selector of a 16-bit word machine into a concrete operand. The machine has eight general registers (indexed 0..7 as A, B, C, X, Y, Z, I, J) and three special registers: stack pointer, program counter and overflow. For a selector, the decoder classifies the operand and reads the selected general register through a read port. When the mode calls for it, the decoder fetches the extra instruction word found at the program counter. It forms the effective memory address and reads the operand from memory. It then presents the operand value, its kind, its address, the adjusted stack pointer and program counter, and a flag telling whether writes to the operand must be thrown away.

A caller pulses `sel_valid` with the selector and the current SP, PC and overflow values. It may also ask for a write-back of `wr_data` to the operand. Once resolution is complete, the block raises `res_valid` for one cycle. In that same cycle it issues any write-back to the general register port, to the special register port or to memory. A write aimed at a literal operand is dropped without any effect. Memory is a synchronous RAM: read data arrives the cycle after a request. Instruction sequencing and arithmetic belong to the caller.

Top module: `opnd_decoder`

## Requirements
- R1: Selectors 0x00..0x07 give kind 0 (general register), with value equal to the register whose index is the low three bits of the selector. They take no extra word, and SP and PC are unchanged.
- R2: Selectors 0x08..0x0f give kind 1 (memory), with address equal to the selected register's value and value equal to memory at that address.
- R3: Selectors 0x10..0x17 fetch the word at PC. They report that an extra word was used, give PC+1 as the new PC, and address memory at that word plus the selected register.
- R4: Selector 0x18 reads memory at SP and gives SP+1 as the new SP.
- R5: Selector 0x19 reads memory at SP and leaves SP unchanged.
- R6: Selector 0x1a decrements SP first, then addresses memory at SP-1 and gives SP-1 as the new SP.
- R7: Selectors 0x1b, 0x1c and 0x1d give kinds 2, 3 and 4, with the values of SP, PC and overflow. A write to one of them drives the special write port with code 0, 1 or 2 respectively.
- R8: Selector 0x1e fetches the word at PC, increments PC, and addresses memory at that word.
- R9: Selector 0x1f gives kind 5 (literal), with value equal to the word at PC and PC+1 as the new PC.
- R10: Selectors 0x20..0x3f give kind 5, with value equal to the selector minus 0x20, no extra word and PC unchanged.
- R11: For selectors 0x1f and above, the discard flag is high and a requested write drives no write strobe. For other selectors, a requested write reaches the register, memory or special port in the result cycle.
- R12: The memory-event flag is high exactly for kind 1 results. Out of reset, no result, request or write is active.
- R13: All address, SP and PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Start resolving `sel` (accepted when not busy) |
| sel | input | 6 | Operand selector |
| wr_en | input | 1 | Request a write-back of `wr_data` to the operand |
| wr_data | input | 16 | Write-back data |
| cur_sp | input | 16 | Current stack pointer |
| cur_pc | input | 16 | Current program counter |
| cur_ovf | input | 16 | Current overflow register |
| busy | output | 1 | A selector is being resolved |
| gpr_idx | output | 3 | General register index |
| gpr_rdata | input | 16 | General register read data (combinational) |
| gpr_we | output | 1 | General register write strobe |
| gpr_wdata | output | 16 | General register write data |
| spec_we | output | 1 | Special register write strobe |
| spec_which | output | 2 | Special register code: 0 SP, 1 PC, 2 overflow |
| spec_wdata | output | 16 | Special register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read request |
| res_valid | output | 1 | Result valid (one cycle) |
| res_kind | output | 3 | Operand kind |
| res_value | output | 16 | Operand value |
| res_addr | output | 16 | Effective memory address |
| res_mem_ev | output | 1 | Memory-access event |
| res_next_word | output | 1 | An extra instruction word was consumed |
| res_sp_new | output | 16 | Stack pointer after the operand |
| res_pc_new | output | 16 | Program counter after the operand |
| res_discard | output | 1 | Writes to this operand are dropped |

## Verification
The hardest situations to reach are the wrap cases, where an address sum or stack step crosses 2^16. They show up only when the fetched word, the register value and SP are arranged to overflow together. The bench seeds the word at PC as 0xfff0 with register I at 0x0020, and pushes with SP at zero. It then peeks at SP=0xffff, which checks through the ports that the push write landed at the wrapped address. Dropped literal writes are caught by counting every write strobe across the whole operation, and by re-reading the registers afterwards.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   typedef enum logic [2:0] {
      OK_GPR = 3'd0,
      OK_MEM = 3'd1,
      OK_SP  = 3'd2,
      OK_PC  = 3'd3,
      OK_OVF = 3'd4,
      OK_LIT = 3'd5
   } opnd_kind_e;

   typedef enum logic [1:0] {
      AB_REG,
      AB_WORD_REG,
      AB_WORD,
      AB_STACK
   } addr_base_e;

   typedef enum logic [1:0] {
      SPOP_NONE,
      SPOP_POST_INC,
      SPOP_PRE_DEC
   } sp_op_e;

   typedef struct packed {
      opnd_kind_e kind;
      logic       need_word;
      logic       mem;
      logic       ro;
      logic       short_lit;
      addr_base_e base;
      sp_op_e     sp_op;
   } opnd_class_t;

endpackage

// File: rtl/opnd_classify.sv
module opnd_classify
   import opnd_pkg::*;
#(
   parameter int SEL_W = 6
) (
   input  logic [SEL_W-1:0] sel,
   output opnd_class_t      cls
);

   localparam int GRP_IND   = 8;
   localparam int GRP_IDX   = 16;
   localparam int GRP_SPEC  = 24;
   localparam int LIT_FIRST = 31;
   localparam int SHORT_BASE = 1 << (SEL_W - 1);

   generate
      if (SEL_W != 6) begin : g_bad_sel_w
         $error("opnd_classify: selector must be 6 bits");
      end
   endgenerate

   always_comb begin
      cls           = '0;
      cls.kind      = OK_GPR;
      cls.base      = AB_REG;
      cls.sp_op     = SPOP_NONE;
      if (int'(sel) < GRP_IND) begin
         cls.kind = OK_GPR;
      end else if (int'(sel) < GRP_IDX) begin
         cls.kind = OK_MEM;
         cls.mem  = 1'b1;
         cls.base = AB_REG;
      end else if (int'(sel) < GRP_SPEC) begin
         cls.kind      = OK_MEM;
         cls.mem       = 1'b1;
         cls.need_word = 1'b1;
         cls.base      = AB_WORD_REG;
      end else if (int'(sel) < SHORT_BASE) begin
         case (sel[2:0])
            3'd0: begin
               cls.kind  = OK_MEM;
               cls.mem   = 1'b1;
               cls.base  = AB_STACK;
               cls.sp_op = SPOP_POST_INC;
            end
            3'd1: begin
               cls.kind = OK_MEM;
               cls.mem  = 1'b1;
               cls.base = AB_STACK;
            end
            3'd2: begin
               cls.kind  = OK_MEM;
               cls.mem   = 1'b1;
               cls.base  = AB_STACK;
               cls.sp_op = SPOP_PRE_DEC;
            end
            3'd3: cls.kind = OK_SP;
            3'd4: cls.kind = OK_PC;
            3'd5: cls.kind = OK_OVF;
            3'd6: begin
               cls.kind      = OK_MEM;
               cls.mem       = 1'b1;
               cls.need_word = 1'b1;
               cls.base      = AB_WORD;
            end
            default: begin
               cls.kind      = OK_LIT;
               cls.need_word = 1'b1;
               cls.ro        = 1'b1;
            end
         endcase
      end else begin
         cls.kind      = OK_LIT;
         cls.ro        = 1'b1;
         cls.short_lit = 1'b1;
      end
   end

   // R11: every selector from the long literal upward is read-only
   always_comb begin
      if (int'(sel) >= LIT_FIRST)
         assert (cls.ro) else $error("p_lit_ro_r11");
   end

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
   import opnd_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  addr_base_e        base,
   input  sp_op_e            sp_op,
   input  logic [WORD_W-1:0] gpr_val,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] sp,
   output logic [WORD_W-1:0] eff_addr,
   output logic [WORD_W-1:0] sp_new
);

   localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

   logic [WORD_W-1:0] sp_dec;
   logic [WORD_W-1:0] sp_inc;
   logic [WORD_W-1:0] stack_addr;

   assign sp_dec     = sp - ONE;
   assign sp_inc     = sp + ONE;
   assign stack_addr = (sp_op == SPOP_PRE_DEC) ? sp_dec : sp;

   always_comb begin
      case (sp_op)
         SPOP_POST_INC: sp_new = sp_inc;
         SPOP_PRE_DEC:  sp_new = sp_dec;
         default:       sp_new = sp;
      endcase
   end

   always_comb begin
      case (base)
         AB_WORD_REG: eff_addr = word + gpr_val;
         AB_WORD:     eff_addr = word;
         AB_STACK:    eff_addr = stack_addr;
         default:     eff_addr = gpr_val;
      endcase
   end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic need_word,
   input  logic mem,
   output logic fetch_req,
   output logic word_cap,
   output logic data_req,
   output logic data_cap,
   output logic fin,
   output logic busy
);

   typedef enum logic [2:0] {
      S_IDLE, S_DEC, S_FW, S_FW2, S_MA, S_MA2, S_FIN
   } seq_state_e;

   seq_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         S_IDLE:  if (start) st_nx = S_DEC;
         S_DEC:   st_nx = need_word ? S_FW : (mem ? S_MA : S_FIN);
         S_FW:    st_nx = S_FW2;
         S_FW2:   st_nx = mem ? S_MA : S_FIN;
         S_MA:    st_nx = S_MA2;
         S_MA2:   st_nx = S_FIN;
         S_FIN:   st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_IDLE;
      else        st <= st_nx;
   end

   assign busy      = (st != S_IDLE);
   assign fetch_req = (st == S_FW);
   assign word_cap  = (st == S_FW2);
   assign data_req  = (st == S_MA);
   assign data_cap  = (st == S_MA2);
   assign fin       = (st == S_FIN);

   // R3: a word fetch is always followed by its capture cycle
   p_fetch_then_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> word_cap);

endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
   import opnd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int SEL_W  = 6,
   parameter int NGPR   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_valid,
   input  logic [SEL_W-1:0]  sel,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] cur_sp,
   input  logic [WORD_W-1:0] cur_pc,
   input  logic [WORD_W-1:0] cur_ovf,
   output logic              busy,
   output logic [2:0]        gpr_idx,
   input  logic [WORD_W-1:0] gpr_rdata,
   output logic              gpr_we,
   output logic [WORD_W-1:0] gpr_wdata,
   output logic              spec_we,
   output logic [1:0]        spec_which,
   output logic [WORD_W-1:0] spec_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              res_valid,
   output logic [2:0]        res_kind,
   output logic [WORD_W-1:0] res_value,
   output logic [WORD_W-1:0] res_addr,
   output logic              res_mem_ev,
   output logic              res_next_word,
   output logic [WORD_W-1:0] res_sp_new,
   output logic [WORD_W-1:0] res_pc_new,
   output logic              res_discard
);

   localparam int GIDX_W = $clog2(NGPR);
   localparam int SHORT_BASE = 1 << (SEL_W - 1);
   localparam logic [WORD_W-1:0] SHORT_OFS = WORD_W'(SHORT_BASE);

   generate
      if (NGPR != 8) begin : g_bad_ngpr
         $error("opnd_decoder: eight general registers required");
      end
      if (WORD_W < SEL_W) begin : g_bad_word
         $error("opnd_decoder: word narrower than selector");
      end
   endgenerate

   logic              accept;
   logic [SEL_W-1:0]  sel_l;
   logic              wr_en_l;
   logic [WORD_W-1:0] wr_data_l, sp_l, pc_l, ovf_l, word_l, data_l;
   opnd_class_t       cls;
   logic [WORD_W-1:0] eff_addr, sp_new;
   logic              fetch_req, word_cap, data_req, data_cap, fin;
   logic              do_wr;

   assign accept = sel_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_l     <= '0;
         wr_en_l   <= 1'b0;
         wr_data_l <= '0;
         sp_l      <= '0;
         pc_l      <= '0;
         ovf_l     <= '0;
         word_l    <= '0;
         data_l    <= '0;
      end else begin
         if (accept) begin
            sel_l     <= sel;
            wr_en_l   <= wr_en;
            wr_data_l <= wr_data;
            sp_l      <= cur_sp;
            pc_l      <= cur_pc;
            ovf_l     <= cur_ovf;
         end
         if (word_cap) word_l <= mem_rdata;
         if (data_cap) data_l <= mem_rdata;
      end
   end

   opnd_classify #(.SEL_W(SEL_W)) u_cls (
      .sel (sel_l),
      .cls (cls)
   );

   opnd_addr_gen #(.WORD_W(WORD_W)) u_agen (
      .base     (cls.base),
      .sp_op    (cls.sp_op),
      .gpr_val  (gpr_rdata),
      .word     (word_l),
      .sp       (sp_l),
      .eff_addr (eff_addr),
      .sp_new   (sp_new)
   );

   opnd_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .need_word (cls.need_word),
      .mem       (cls.mem),
      .fetch_req (fetch_req),
      .word_cap  (word_cap),
      .data_req  (data_req),
      .data_cap  (data_cap),
      .fin       (fin),
      .busy      (busy)
   );

   assign gpr_idx = 3'(sel_l[GIDX_W-1:0]);

   always_comb begin
      case (cls.kind)
         OK_MEM:  res_value = data_l;
         OK_SP:   res_value = sp_l;
         OK_PC:   res_value = pc_l;
         OK_OVF:  res_value = ovf_l;
         OK_LIT:  res_value = cls.short_lit ? (WORD_W'(sel_l) - SHORT_OFS) : word_l;
         default: res_value = gpr_rdata;
      endcase
   end

   assign res_valid     = fin;
   assign res_kind      = cls.kind;
   assign res_addr      = eff_addr;
   assign res_mem_ev    = cls.mem;
   assign res_next_word = cls.need_word;
   assign res_sp_new    = sp_new;
   assign res_pc_new    = pc_l + WORD_W'(cls.need_word);
   assign res_discard   = cls.ro;

   assign do_wr      = fin && wr_en_l && !cls.ro;
   assign gpr_we     = do_wr && (cls.kind == OK_GPR);
   assign gpr_wdata  = wr_data_l;
   assign spec_we    = do_wr && ((cls.kind == OK_SP) || (cls.kind == OK_PC) || (cls.kind == OK_OVF));
   assign spec_which = (cls.kind == OK_SP) ? 2'd0 : ((cls.kind == OK_PC) ? 2'd1 : 2'd2);
   assign spec_wdata = wr_data_l;

   assign mem_we    = do_wr && (cls.kind == OK_MEM);
   assign mem_req   = fetch_req || data_req || mem_we;
   assign mem_addr  = fetch_req ? pc_l : eff_addr;
   assign mem_wdata = wr_data_l;

   // R11: discarded operands raise no write strobe of any kind
   p_discard_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_discard) |-> !(gpr_we || mem_we || spec_we));

   // R4: pop steps SP one past the address it read
   p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && sel_l == SEL_W'(8'h18)) |-> (res_sp_new == res_addr + WORD_W'(1)));

   // R6: push addresses the already-decremented SP
   p_push_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && sel_l == SEL_W'(8'h1a)) |-> (res_sp_new == res_addr));

   // R10: short literals use no memory and leave PC alone
   p_short_lit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && int'(sel_l) >= SHORT_BASE) |-> (!res_mem_ev && res_discard && res_pc_new == pc_l));

   // R12: a result lasts exactly one cycle
   p_res_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R3: memory reads never come back-to-back
   p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !mem_req);

endmodule

// File: tb/sim_opnd_decoder.sv
module sim_opnd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_valid = 1'b0;
   logic [5:0]  sel = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] cur_sp = '0, cur_pc = '0, cur_ovf = '0;
   logic        busy;
   logic [2:0]  gpr_idx;
   logic [15:0] gpr_rdata;
   logic        gpr_we;
   logic [15:0] gpr_wdata;
   logic        spec_we;
   logic [1:0]  spec_which;
   logic [15:0] spec_wdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        res_valid;
   logic [2:0]  res_kind;
   logic [15:0] res_value, res_addr;
   logic        res_mem_ev, res_next_word;
   logic [15:0] res_sp_new, res_pc_new;
   logic        res_discard;

   always #5 clk = ~clk;

   opnd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel(sel),
      .wr_en(wr_en), .wr_data(wr_data), .cur_sp(cur_sp), .cur_pc(cur_pc),
      .cur_ovf(cur_ovf), .busy(busy), .gpr_idx(gpr_idx), .gpr_rdata(gpr_rdata),
      .gpr_we(gpr_we), .gpr_wdata(gpr_wdata), .spec_we(spec_we),
      .spec_which(spec_which), .spec_wdata(spec_wdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .res_kind(res_kind),
      .res_value(res_value), .res_addr(res_addr), .res_mem_ev(res_mem_ev),
      .res_next_word(res_next_word), .res_sp_new(res_sp_new),
      .res_pc_new(res_pc_new), .res_discard(res_discard)
   );

   // external register file and memory models
   logic [15:0] regs [8];
   logic [15:0] mem_wr [int];
   assign gpr_rdata = regs[gpr_idx];

   function automatic logic [15:0] rd(logic [15:0] a);
      if (mem_wr.exists(int'(a))) return mem_wr[int'(a)];
      return a ^ 16'h5a3c;
   endfunction

   always @(posedge clk) begin
      if (gpr_we) regs[gpr_idx] = gpr_wdata;
      if (mem_req && mem_we) mem_wr[int'(mem_addr)] = mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= rd(mem_addr);
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // captured results
   logic [2:0]  c_kind;
   logic [15:0] c_val, c_addr, c_sp, c_pc, c_swd;
   logic        c_ev, c_nw, c_ro, c_got;
   logic [1:0]  c_swh;
   int          n_gwe, n_mwe, n_swe;

   task automatic run_op(logic [5:0] s, logic w, logic [15:0] wd);
      @(negedge clk);
      sel = s; wr_en = w; wr_data = wd; sel_valid = 1'b1;
      @(negedge clk);
      sel_valid = 1'b0; wr_en = 1'b0;
      n_gwe = 0; n_mwe = 0; n_swe = 0; c_got = 1'b0;
      for (int k = 0; k < 12; k++) begin
         if (gpr_we) n_gwe++;
         if (mem_req && mem_we) n_mwe++;
         if (spec_we) n_swe++;
         if (res_valid) begin
            c_got = 1'b1; c_kind = res_kind; c_val = res_value; c_addr = res_addr;
            c_sp = res_sp_new; c_pc = res_pc_new; c_ev = res_mem_ev;
            c_nw = res_next_word; c_ro = res_discard; c_swh = spec_which;
            c_swd = spec_wdata;
            break;
         end
         @(negedge clk);
      end
      chk("R12 result arrives", 16'(c_got), 16'd1);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R12 reset res_valid", 16'(res_valid), 16'd0);
      chk("R12 reset mem_req", 16'(mem_req), 16'd0);
      chk("R12 reset busy", 16'(busy), 16'd0);
      chk("R12 reset writes", 16'({gpr_we, spec_we}), 16'd0);
   endtask

   task automatic t_direct();
      cur_sp = 16'h1000; cur_pc = 16'h0040;
      for (int i = 0; i < 8; i++) begin
         run_op(6'(i), 1'b0, 16'h0);
         chk("R1 kind", 16'(c_kind), 16'd0);
         chk("R1 value", c_val, regs[i]);
         chk("R1 no word", 16'(c_nw), 16'd0);
         chk("R1 pc", c_pc, 16'h0040);
         chk("R12 no event", 16'(c_ev), 16'd0);
      end
      run_op(6'h03, 1'b1, 16'h7777);
      chk("R11 gpr write strobe", 16'(n_gwe), 16'd1);
      chk("R11 gpr write lands", regs[3], 16'h7777);
   endtask

   task automatic t_indirect();
      regs[2] = 16'h1234;
      run_op(6'h0a, 1'b0, 16'h0);
      chk("R2 kind", 16'(c_kind), 16'd1);
      chk("R2 addr", c_addr, 16'h1234);
      chk("R2 value", c_val, rd(16'h1234));
      chk("R12 event", 16'(c_ev), 16'd1);
   endtask

   task automatic t_indexed();
      cur_pc = 16'h0100; mem_wr[32'h0100] = 16'hfff0; regs[6] = 16'h0020;
      run_op(6'h16, 1'b0, 16'h0);
      chk("R3 next word", 16'(c_nw), 16'd1);
      chk("R3 pc", c_pc, 16'h0101);
      chk("R13 wrapped addr", c_addr, 16'h0010);
      chk("R3 value", c_val, rd(16'h0010));
   endtask

   task automatic t_stack();
      cur_sp = 16'h8000;
      run_op(6'h18, 1'b0, 16'h0);
      chk("R4 addr", c_addr, 16'h8000);
      chk("R4 sp", c_sp, 16'h8001);
      chk("R4 value", c_val, rd(16'h8000));
      run_op(6'h19, 1'b0, 16'h0);
      chk("R5 addr", c_addr, 16'h8000);
      chk("R5 sp", c_sp, 16'h8000);
      cur_sp = 16'h0000;
      run_op(6'h1a, 1'b1, 16'hbeef);
      chk("R6 addr", c_addr, 16'hffff);
      chk("R13 sp wrap", c_sp, 16'hffff);
      chk("R11 mem write strobe", 16'(n_mwe), 16'd1);
      cur_sp = 16'hffff;
      run_op(6'h19, 1'b0, 16'h0);
      chk("R6 push stored", c_val, 16'hbeef);
   endtask

   task automatic t_special();
      cur_sp = 16'h2222; cur_pc = 16'h3333; cur_ovf = 16'h4444;
      run_op(6'h1b, 1'b0, 16'h0);
      chk("R7 sp kind", 16'(c_kind), 16'd2);
      chk("R7 sp value", c_val, 16'h2222);
      run_op(6'h1c, 1'b0, 16'h0);
      chk("R7 pc kind", 16'(c_kind), 16'd3);
      chk("R7 pc value", c_val, 16'h3333);
      run_op(6'h1d, 1'b1, 16'h0abc);
      chk("R7 ovf kind", 16'(c_kind), 16'd4);
      chk("R7 ovf value", c_val, 16'h4444);
      chk("R7 spec write", 16'(n_swe), 16'd1);
      chk("R7 spec code", 16'(c_swh), 16'd2);
      chk("R7 spec data", c_swd, 16'h0abc);
   endtask

   task automatic t_word_addr();
      cur_pc = 16'h0500; mem_wr[32'h0500] = 16'h4444;
      run_op(6'h1e, 1'b0, 16'h0);
      chk("R8 addr", c_addr, 16'h4444);
      chk("R8 pc", c_pc, 16'h0501);
      chk("R8 value", c_val, rd(16'h4444));
   endtask

   task automatic t_literal();
      logic [15:0] snap [8];
      cur_pc = 16'h0200;
      foreach (regs[i]) snap[i] = regs[i];
      run_op(6'h1f, 1'b1, 16'hdead);
      chk("R9 kind", 16'(c_kind), 16'd5);
      chk("R9 value", c_val, rd(16'h0200));
      chk("R9 pc", c_pc, 16'h0201);
      chk("R11 discard", 16'(c_ro), 16'd1);
      chk("R11 no write", 16'(n_gwe + n_mwe + n_swe), 16'd0);
      chk("R11 mem untouched", rd(16'h0200), 16'h0200 ^ 16'h5a3c);
      run_op(6'h20, 1'b0, 16'h0);
      chk("R10 value 0x20", c_val, 16'h0000);
      run_op(6'h3f, 1'b0, 16'h0);
      chk("R10 value 0x3f", c_val, 16'h001f);
      run_op(6'h25, 1'b1, 16'hdead);
      chk("R10 value 0x25", c_val, 16'h0005);
      chk("R10 no word", 16'(c_nw), 16'd0);
      chk("R10 pc", c_pc, 16'h0200);
      chk("R12 no event", 16'(c_ev), 16'd0);
      chk("R11 no write short", 16'(n_gwe + n_mwe + n_swe), 16'd0);
      for (int i = 0; i < 8; i++) chk("R11 regs kept", regs[i], snap[i]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = 16'h0a00 + 16'(i * 16'h0111);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_direct();
      t_indirect();
      t_indexed();
      t_stack();
      t_special();
      t_word_addr();
      t_literal();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule